// File: doc/BRIEF.md
# Accelerator Register Front End

This block gives a host a 32-bit, word-addressed register bank in front of a long-running 256-bit arithmetic engine. The host loads a 256-bit scalar into an eight-word input buffer, with the least significant word first. It then launches the engine by moving a control bit from 0 to 1. The host polls a sticky completion flag and reads two eight-word result buffers, X and Y. Identification words at the bottom of the map let software confirm what it is talking to.

On the engine side the block offers a one-cycle start pulse and the scalar as a parallel 256-bit vector. It accepts a done strobe and two parallel 256-bit results. The results are latched on done, so the host reads a stable copy even if the engine's outputs move afterwards. Host reads are registered. Writes to read-only or unmapped words have no effect.

Top module: `accel_regfront`

## Requirements
- R1: Reads of word 0 and word 1 return the parameter identification words ID_WORD0 and ID_WORD1. A read of word 2 returns the parameter VERSION.
- R2: A read (host_cs=1, host_we=0) updates host_rdata at the clock edge that samples the strobe. In every other cycle host_rdata holds its value.
- R3: Reads of unmapped words (3 to 7, 10 to 0x1F, 0x38 to 0x3F) return 0. Writes to unmapped words and to words 0, 1, 2 and 9 change no readable state.
- R4: Scalar word i (address 0x20+i, i = 0 to 7) is writable and readable. It drives eng_scalar bits [32i+31:32i], so word 0 is the least significant word.
- R5: The control register is at address 8. Only bit 1 (the launch bit) is stored, and it reads back at bit 1. All other bits read 0.
- R6: A write to address 8 that changes the stored launch bit from 0 to 1 produces eng_start high for exactly one cycle, starting at the edge that takes the write. A write of 1 while the bit is already 1 produces no pulse.
- R7: The status register is at address 9 and its bit 1 is the valid flag. The flag clears when eng_start fires and sets on the edge that samples eng_done while the engine is busy. It stays set until the next start. All other status bits read 0.
- R8: On the edge that sets valid, eng_res_x and eng_res_y are copied into the X buffer (0x28+i) and the Y buffer (0x30+i), with word i taken from bits [32i+31:32i]. The two buffers are read-only to the host.
- R9: From the start pulse until done, writes to the scalar buffer are ignored and eng_scalar stays constant.
- R10: A 0-to-1 launch transition while the engine is busy issues no start pulse. The stored launch bit still follows the write.
- R11: After reset, host_rdata, eng_start, the launch bit, the valid flag, the scalar buffer and the result buffers are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Access strobe, one cycle per access |
| host_we | input | 1 | 1 selects a write, 0 a read |
| host_addr | input | 6 | Word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| eng_start | output | 1 | One-cycle engine launch pulse |
| eng_done | input | 1 | Engine completion strobe |
| eng_scalar | output | 256 | Scalar operand to the engine |
| eng_res_x | input | 256 | Engine X result |
| eng_res_y | input | 256 | Engine Y result |

## Verification
The bench targets the launch edge detector in several ways:
- It writes 1 twice in a row and expects no second pulse. A level-sensitive launch would restart the engine here.
- It re-arms the launch bit while busy and expects no start. A design that missed this would abort a run in flight.

It writes the scalar buffer mid-operation and expects the write to be ignored. A design that missed this would corrupt the operand under the engine.

It changes the engine result inputs after done and reads them back. A design reading live inputs instead of latched copies would return the new values.

It also checks:
- word order at both ends of every buffer, where a swapped order shows up at once;
- writes to the identification and status words, and reads of unmapped holes, which an incomplete decoder would get wrong;
- a reset taken after valid has been set.

// File: rtl/arf_pkg.sv
package arf_pkg;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_ID0  = 6'h00;
  localparam logic [AW-1:0] A_ID1  = 6'h01;
  localparam logic [AW-1:0] A_VER  = 6'h02;
  localparam logic [AW-1:0] A_CTRL = 6'h08;
  localparam logic [AW-1:0] A_STAT = 6'h09;
  localparam logic [AW-1:0] A_SCAL = 6'h20;
  localparam logic [AW-1:0] A_RESX = 6'h28;
  localparam logic [AW-1:0] A_RESY = 6'h30;
  localparam int GO_BIT    = 1;
  localparam int VALID_BIT = 1;
endpackage

// File: rtl/arf_launch.sv
module arf_launch #(
  parameter int GO = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic go_in,
  input  logic done,
  output logic go_q,
  output logic busy_q,
  output logic valid_q,
  output logic start_q,
  output logic capture
);
  logic fire;

  assign fire    = ctrl_wr & go_in & ~go_q & ~busy_q;
  assign capture = done & busy_q & ~fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q    <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (ctrl_wr) go_q <= go_in;
      start_q <= fire;
      if (fire) begin
        busy_q  <= 1'b1;
        valid_q <= 1'b0;
      end else if (capture) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/arf_opbuf.sv
module arf_opbuf #(
  parameter int DW     = 32,
  parameter int NWORDS = 8,
  localparam int IDXW  = $clog2(NWORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [IDXW-1:0]      idx,
  input  logic [DW-1:0]        wdata,
  output logic [DW*NWORDS-1:0] vec
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                     vec[w*DW +: DW] <= '0;
      else if (wr && idx == IDXW'(w))              vec[w*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/arf_resbuf.sv
module arf_resbuf #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (cap) dout <= din;
  end
endmodule

// File: rtl/accel_regfront.sv
module accel_regfront
  import arf_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          NWORDS   = 8,
  parameter logic [31:0] ID_WORD0 = 32'h61636365,
  parameter logic [31:0] ID_WORD1 = 32'h6c667274,
  parameter logic [31:0] VERSION  = 32'h00010003,
  localparam int         OPW      = DW * NWORDS,
  localparam int         IDXW     = $clog2(NWORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_cs,
  input  logic           host_we,
  input  logic [AW-1:0]  host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           eng_start,
  input  logic           eng_done,
  output logic [OPW-1:0] eng_scalar,
  input  logic [OPW-1:0] eng_res_x,
  input  logic [OPW-1:0] eng_res_y
);
  logic                 wr, rd;
  logic [AW-IDXW-1:0]   region;
  logic [IDXW-1:0]      idx;
  logic                 sel_scal, sel_resx, sel_resy;
  logic                 go_q, busy_q, valid_q, capture;
  logic [OPW-1:0]       resx_q, resy_q;
  logic [DW-1:0]        rd_next;

  assign wr       = host_cs & host_we;
  assign rd       = host_cs & ~host_we;
  assign region   = host_addr[AW-1:IDXW];
  assign idx      = host_addr[IDXW-1:0];
  assign sel_scal = region == A_SCAL[AW-1:IDXW];
  assign sel_resx = region == A_RESX[AW-1:IDXW];
  assign sel_resy = region == A_RESY[AW-1:IDXW];

  arf_launch #(.GO(GO_BIT)) u_launch (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (wr && host_addr == A_CTRL),
    .go_in   (host_wdata[GO_BIT]),
    .done    (eng_done),
    .go_q    (go_q),
    .busy_q  (busy_q),
    .valid_q (valid_q),
    .start_q (eng_start),
    .capture (capture)
  );

  arf_opbuf #(.DW(DW), .NWORDS(NWORDS)) u_scal (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr && sel_scal && !busy_q),
    .idx   (idx),
    .wdata (host_wdata),
    .vec   (eng_scalar)
  );

  arf_resbuf #(.W(OPW)) u_resx (
    .clk (clk), .rst (rst), .cap (capture), .din (eng_res_x), .dout (resx_q)
  );

  arf_resbuf #(.W(OPW)) u_resy (
    .clk (clk), .rst (rst), .cap (capture), .din (eng_res_y), .dout (resy_q)
  );

  always_comb begin
    rd_next = '0;
    if (sel_scal)      rd_next = eng_scalar[int'(idx)*DW +: DW];
    else if (sel_resx) rd_next = resx_q[int'(idx)*DW +: DW];
    else if (sel_resy) rd_next = resy_q[int'(idx)*DW +: DW];
    else begin
      case (host_addr)
        A_ID0:   rd_next = ID_WORD0;
        A_ID1:   rd_next = ID_WORD1;
        A_VER:   rd_next = VERSION;
        A_CTRL:  rd_next[GO_BIT] = go_q;
        A_STAT:  rd_next[VALID_BIT] = valid_q;
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     host_rdata <= '0;
    else if (rd) host_rdata <= rd_next;
  end
endmodule

// File: rtl/arf_checker.sv
module arf_checker
  import arf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NWORDS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 host_cs,
  input logic                 host_we,
  input logic [AW-1:0]        host_addr,
  input logic [DW-1:0]        host_wdata,
  input logic [DW-1:0]        host_rdata,
  input logic                 eng_start,
  input logic                 eng_done,
  input logic [DW*NWORDS-1:0] eng_scalar,
  input logic                 busy,
  input logic                 valid
);
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(host_cs && !host_we) |=> $stable(host_rdata));

  assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  assert_start_cause_R6: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(host_cs && host_we && host_addr == A_CTRL && host_wdata[GO_BIT]));

  assert_valid_clear_R7: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !valid);

  assert_valid_set_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(eng_done));

  assert_scalar_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(eng_scalar));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_start) |=> !eng_start);
endmodule

bind accel_regfront arf_checker #(.DW(DW), .NWORDS(NWORDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_cs    (host_cs),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .eng_start  (eng_start),
  .eng_done   (eng_done),
  .eng_scalar (eng_scalar),
  .busy       (busy_q),
  .valid      (valid_q)
);

// File: tb/tb_accel_regfront.sv
module tb_accel_regfront;
  localparam logic [31:0] ID0 = 32'h61636365;
  localparam logic [31:0] ID1 = 32'h6c667274;
  localparam logic [31:0] VER = 32'h00010003;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         host_cs = 1'b0, host_we = 1'b0;
  logic [5:0]   host_addr = '0;
  logic [31:0]  host_wdata = '0;
  logic [31:0]  host_rdata;
  logic         eng_start;
  logic         eng_done = 1'b0;
  logic [255:0] eng_scalar;
  logic [255:0] eng_res_x = '0, eng_res_y = '0;

  int nchk = 0, nfail = 0, start_cnt = 0, cyc = 0;

  always #5 clk = ~clk;

  accel_regfront dut (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_start(eng_start), .eng_done(eng_done), .eng_scalar(eng_scalar),
    .eng_res_x(eng_res_x), .eng_res_y(eng_res_y)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (eng_start) start_cnt <= start_cnt + 1;
  end

  initial begin
    wait (cyc == 20000);
    nchk++; nfail++;
    $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_cs = 1'b0;
    d = host_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // {req[3:0], we, addr[5:0], wdata[31:0], expected[31:0]}
  localparam int NV = 20;
  localparam logic [74:0] VEC [NV] = '{
    {4'd1,  1'b0, 6'h00, 32'h0,        ID0},          // R1
    {4'd1,  1'b0, 6'h01, 32'h0,        ID1},          // R1
    {4'd1,  1'b0, 6'h02, 32'h0,        VER},          // R1
    {4'd11, 1'b0, 6'h08, 32'h0,        32'h0},        // R11 launch bit
    {4'd11, 1'b0, 6'h09, 32'h0,        32'h0},        // R11 valid
    {4'd3,  1'b0, 6'h03, 32'h0,        32'h0},        // R3
    {4'd3,  1'b0, 6'h38, 32'h0,        32'h0},        // R3
    {4'd4,  1'b1, 6'h20, 32'h11111111, 32'h0},        // R4
    {4'd4,  1'b1, 6'h27, 32'h77777777, 32'h0},        // R4
    {4'd4,  1'b0, 6'h20, 32'h0,        32'h11111111}, // R4
    {4'd4,  1'b0, 6'h27, 32'h0,        32'h77777777}, // R4
    {4'd8,  1'b1, 6'h28, 32'hdeadbeef, 32'h0},        // R8
    {4'd8,  1'b0, 6'h28, 32'h0,        32'h0},        // R8
    {4'd3,  1'b1, 6'h00, 32'hffffffff, 32'h0},        // R3
    {4'd3,  1'b0, 6'h00, 32'h0,        ID0},          // R3
    {4'd3,  1'b1, 6'h3f, 32'h12345678, 32'h0},        // R3
    {4'd3,  1'b0, 6'h3f, 32'h0,        32'h0},        // R3
    {4'd3,  1'b1, 6'h09, 32'hffffffff, 32'h0},        // R3
    {4'd3,  1'b0, 6'h09, 32'h0,        32'h0},        // R3
    {4'd5,  1'b1, 6'h08, 32'hfffffffd, 32'h0}         // R5
  };

  logic [31:0]  rv;
  logic [255:0] expv, gx, gy;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state at the ports
    check("R11 rdata", 256'(host_rdata), 256'h0);
    check("R11 start", 256'(eng_start), 256'h0);
    check("R11 scalar", eng_scalar, 256'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) bus_write(VEC[i][69:64], VEC[i][63:32]);
      else begin
        bus_read(VEC[i][69:64], rv);
        check($sformatf("R%0d vec%0d", VEC[i][74:71], i), 256'(rv), 256'(VEC[i][31:0]));
      end
    end
    // R5 only bit 1 stored: the write of 0xfffffffd left it 0
    bus_read(6'h08, rv); check("R5 ctrl other bits", 256'(rv), 256'h0);
    check("R4 word order", eng_scalar, {32'h77777777, 192'h0, 32'h11111111});

    // R2 read data holds while no read strobe
    bus_read(6'h01, rv);
    repeat (3) @(negedge clk);
    check("R2 hold", 256'(host_rdata), 256'(ID1));

    // R4 full scalar load
    expv = '0;
    for (int i = 0; i < 8; i++) begin
      bus_write(6'h20 + 6'(i), 32'ha0000000 + 32'(i));
      expv[i*32 +: 32] = 32'ha0000000 + 32'(i);
    end
    check("R4 scalar vector", eng_scalar, expv);

    // R6 launch edge
    bus_write(6'h08, 32'h0);
    check("R6 no pulse on 0", 256'(start_cnt), 256'd0);
    bus_write(6'h08, 32'h2);
    check("R6 pulse high", 256'(eng_start), 256'd1);
    @(negedge clk);
    check("R6 pulse one cycle", 256'(eng_start), 256'd0);
    check("R6 pulse count", 256'(start_cnt), 256'd1);
    bus_read(6'h08, rv); check("R5 ctrl readback", 256'(rv), 256'h2);
    bus_read(6'h09, rv); check("R7 valid cleared", 256'(rv), 256'h0);

    // R9 scalar write ignored while busy
    bus_write(6'h20, 32'h55555555);
    bus_read(6'h20, rv); check("R9 scalar frozen", 256'(rv), 256'ha0000000);
    check("R9 scalar vector", eng_scalar, expv);

    // R6 level 1 again: no pulse
    bus_write(6'h08, 32'h2);
    @(negedge clk);
    check("R6 repeat 1 no pulse", 256'(start_cnt), 256'd1);

    // R10 re-arm while busy
    bus_write(6'h08, 32'h0);
    bus_write(6'h08, 32'h2);
    @(negedge clk);
    check("R10 no start while busy", 256'(start_cnt), 256'd1);
    bus_read(6'h08, rv); check("R10 bit follows", 256'(rv), 256'h2);

    // R7/R8 completion and capture
    for (int i = 0; i < 8; i++) begin
      gx[i*32 +: 32] = 32'h10000000 + 32'(i * 32'h111);
      gy[i*32 +: 32] = 32'h20000000 + 32'(i * 32'h333);
    end
    eng_res_x = gx; eng_res_y = gy;
    pulse_done();
    eng_res_x = ~gx; eng_res_y = ~gy;
    bus_read(6'h09, rv); check("R7 valid set", 256'(rv), 256'h2);
    for (int i = 0; i < 8; i++) begin
      bus_read(6'h28 + 6'(i), rv);
      check($sformatf("R8 X word %0d", i), 256'(rv), 256'(gx[i*32 +: 32]));
      bus_read(6'h30 + 6'(i), rv);
      check($sformatf("R8 Y word %0d", i), 256'(rv), 256'(gy[i*32 +: 32]));
    end
    bus_write(6'h37, 32'h0);
    bus_read(6'h37, rv); check("R8 Y read-only", 256'(rv), 256'(gy[255:224]));
    repeat (5) @(negedge clk);
    bus_read(6'h09, rv); check("R7 valid sticky", 256'(rv), 256'h2);

    // R9 scalar writable again after done
    bus_write(6'h20, 32'h55555555);
    bus_read(6'h20, rv); check("R9 writable when idle", 256'(rv), 256'h55555555);

    // second launch clears valid
    bus_write(6'h08, 32'h0);
    bus_write(6'h08, 32'h2);
    @(negedge clk);
    check("R6 second pulse", 256'(start_cnt), 256'd2);
    bus_read(6'h09, rv); check("R7 valid cleared again", 256'(rv), 256'h0);
    pulse_done();
    bus_read(6'h09, rv); check("R7 valid set again", 256'(rv), 256'h2);

    // R11 reset after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R11 rdata after reset", 256'(host_rdata), 256'h0);
    check("R11 scalar after reset", eng_scalar, 256'h0);
    bus_read(6'h09, rv); check("R11 valid after reset", 256'(rv), 256'h0);
    bus_read(6'h08, rv); check("R11 ctrl after reset", 256'(rv), 256'h0);
    bus_read(6'h28, rv); check("R11 X after reset", 256'(rv), 256'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule